// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits next to a single-error-correct, double-error-detect memory datapath and records the first ECC event the datapath reports. The datapath drives a corrected-error pulse or an uncorrectable-error pulse, together with the failing byte address and the 8-bit syndrome. The block latches the upper address bits and the syndrome into a 32-bit capture register and sets a sticky flag for the kind of error. It keeps that record until software clears it, so a second error cannot overwrite evidence of the first one.

Software reaches two registers through a simple read/write port. The capture register holds the logged error, the write-one-to-clear flags and three enables: scrub suppression, an interrupt on corrected errors and a bus error on uncorrectable errors. The control register holds a global ECC enable and a test mode that forces every check bit to zero on memory write cycles. The outputs are a non-maskable interrupt request, a bus system-error request and a scrub request. Each one is a single-cycle pulse issued when an error is captured.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset both registers read as zero, the three request outputs are low, and `chk_out` follows `chk_in`.
- R2: With ECC enabled and both flags clear, a corrected-error pulse sets capture-register bit 0. It also loads bits 30:12 with failing-address bits 32:14 (16 KB granularity) and bits 11:4 with the syndrome.
- R3: With ECC enabled and both flags clear, an uncorrectable-error pulse sets capture-register bit 1 and loads the address and syndrome fields in the same way as R2.
- R4: While either flag is set, further error pulses of either kind leave both flags, the address field and the syndrome field unchanged.
- R5: A write to the capture register (select 0) clears each flag whose data bit (1 for bit 1, 0 for bit 0) is 1. A 0 leaves the flag unchanged. Capture is re-armed only once no flag remains set.
- R6: If both error pulses arrive in the same cycle, only the uncorrectable flag (bit 1) is set.
- R7: If a write that leaves no flag set coincides with a new error pulse, the new error is captured.
- R8: When control-register (select 1) bit 0, the ECC enable, is 0, error pulses set no flag and capture nothing.
- R9: When a corrected error is captured and capture-register bit 2 is 1, `nmi_req` is high for exactly the cycle in which the flag first reads as set.
- R10: When an uncorrectable error is captured and capture-register bit 3 is 1, `berr_req` pulses in the same way as R9.
- R11: When a corrected error is captured and capture-register bit 31 is 0, `scrub_req` pulses in the same way as R9. When bit 31 is 1, `scrub_req` stays low.
- R12: Capture bits 31, 3 and 2 and control bits 1:0 read back as written. Writes to the address and syndrome fields have no effect.
- R13: While control-register bit 1 is 1 and `mem_wr_cycle` is high, `chk_out` is all zeros. Otherwise it equals `chk_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 capture, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ce_evt | input | 1 | Corrected-error pulse from the datapath |
| ue_evt | input | 1 | Uncorrectable-error pulse from the datapath |
| evt_addr | input | ERR_ADDR_W | Failing byte address |
| evt_syn | input | 8 | Syndrome of the failing word |
| mem_wr_cycle | input | 1 | Datapath is performing a memory write |
| chk_in | input | CHK_W | Check bits from the encoder |
| chk_out | output | CHK_W | Check bits toward memory |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| berr_req | output | 1 | Bus system-error request pulse |
| scrub_req | output | 1 | Corrected write-back request pulse |

## Verification
Software clearing the flags and the datapath reporting a new error can land in the same clock cycle. Simultaneous corrected and uncorrectable pulses can also collide. The bench drives a clear write and an error pulse at the same falling edge, then reads back the register to judge which record survived: a clear that leaves no flag set must yield the new error, and a write that clears nothing must yield the old one. It also drives both error pulses together across every enable combination and expects only the uncorrectable flag and its bus-error pulse.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_KEEP = 19;
    localparam int SYN_W     = 8;

    localparam logic SEL_CAP = 1'b0;
    localparam logic SEL_CTL = 1'b1;

    // Capture register, MSB first: bit 31 down to bit 0.
    typedef struct packed {
        logic                 scrub_off;
        logic [ADDR_KEEP-1:0] addr_hi;
        logic [SYN_W-1:0]     syn;
        logic                 berr_en;
        logic                 nmi_en;
        logic                 ue;
        logic                 ce;
    } cap_reg_t;

    typedef struct packed {
        logic force_chk;
        logic ecc_on;
    } ctl_reg_t;

    typedef enum logic [1:0] {
        EVT_NONE = 2'd0,
        EVT_CE   = 2'd1,
        EVT_UE   = 2'd2
    } evt_kind_e;

    function automatic logic [REG_W-1:0] ctl_to_word(input ctl_reg_t c);
        return {{(REG_W-2){1'b0}}, c};
    endfunction

    function automatic logic [1:0] kind_to_flags(input evt_kind_e k);
        return {k == EVT_UE, k == EVT_CE};
    endfunction

endpackage

// File: rtl/ecc_cap_ctl.sv
module ecc_cap_ctl
    import ecc_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output ctl_reg_t         ctl,
    output logic             scrub_off,
    output logic             nmi_en,
    output logic             berr_en,
    output logic [1:0]       clr_mask
);
    cap_reg_t wr_cap;
    logic     wr_to_cap;
    logic     wr_to_ctl;

    assign wr_cap    = cap_reg_t'(reg_wdata);
    assign wr_to_cap = reg_wr && (reg_sel == SEL_CAP);
    assign wr_to_ctl = reg_wr && (reg_sel == SEL_CTL);

    // W1C mask is only live on a capture-register write.
    assign clr_mask  = wr_to_cap ? {wr_cap.ue, wr_cap.ce} : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            scrub_off <= 1'b0;
            nmi_en    <= 1'b0;
            berr_en   <= 1'b0;
        end else begin
            if (wr_to_ctl) begin
                ctl <= ctl_reg_t'(reg_wdata[1:0]);
            end
            if (wr_to_cap) begin
                scrub_off <= wr_cap.scrub_off;
                nmi_en    <= wr_cap.nmi_en;
                berr_en   <= wr_cap.berr_en;
            end
        end
    end
endmodule

// File: rtl/ecc_cap_arb.sv
module ecc_cap_arb
    import ecc_cap_pkg::*;
(
    input  logic      ce_evt,
    input  logic      ue_evt,
    input  logic      ecc_on,
    input  logic      armed,
    output evt_kind_e kind
);
    // Uncorrectable wins a tie; nothing is taken unless enabled and armed.
    always_comb begin
        kind = EVT_NONE;
        if (ecc_on && armed) begin
            if (ue_evt) begin
                kind = EVT_UE;
            end else if (ce_evt) begin
                kind = EVT_CE;
            end
        end
    end
endmodule

// File: rtl/ecc_cap_log.sv
module ecc_cap_log
    import ecc_cap_pkg::*;
#(
    parameter int ERR_ADDR_W = 33
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            clr_mask,
    input  evt_kind_e             kind,
    input  logic [ERR_ADDR_W-1:0] evt_addr,
    input  logic [SYN_W-1:0]      evt_syn,
    output logic [1:0]            flags,
    output logic [ADDR_KEEP-1:0]  addr_hi,
    output logic [SYN_W-1:0]      syn_q,
    output logic                  armed
);
    localparam int ADDR_LSB = ERR_ADDR_W - ADDR_KEEP;

    logic [1:0] flags_left;

    assign flags_left = flags & ~clr_mask;
    // A clear that leaves nothing set re-arms capture in the same cycle.
    assign armed      = (flags_left == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= 2'b00;
            addr_hi <= '0;
            syn_q   <= '0;
        end else if (kind != EVT_NONE) begin
            flags   <= kind_to_flags(kind);
            addr_hi <= evt_addr[ERR_ADDR_W-1:ADDR_LSB];
            syn_q   <= evt_syn;
        end else begin
            flags   <= flags_left;
        end
    end
endmodule

// File: rtl/ecc_cap_notify.sv
module ecc_cap_notify
    import ecc_cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  evt_kind_e kind,
    input  logic      nmi_en,
    input  logic      berr_en,
    input  logic      scrub_off,
    output logic      nmi_req,
    output logic      berr_req,
    output logic      scrub_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_req   <= 1'b0;
            berr_req  <= 1'b0;
            scrub_req <= 1'b0;
        end else begin
            nmi_req   <= (kind == EVT_CE) && nmi_en;
            berr_req  <= (kind == EVT_UE) && berr_en;
            scrub_req <= (kind == EVT_CE) && !scrub_off;
        end
    end
endmodule

// File: rtl/ecc_cap_chkmask.sv
module ecc_cap_chkmask #(
    parameter int CHK_W = 8
) (
    input  logic             force_chk,
    input  logic             mem_wr_cycle,
    input  logic [CHK_W-1:0] chk_in,
    output logic [CHK_W-1:0] chk_out
);
    logic zero_all;

    assign zero_all = force_chk && mem_wr_cycle;

    for (genvar i = 0; i < CHK_W; i++) begin : g_bit
        assign chk_out[i] = chk_in[i] && !zero_all;
    end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ERR_ADDR_W = 33,
    parameter int CHK_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic                  reg_sel,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  ce_evt,
    input  logic                  ue_evt,
    input  logic [ERR_ADDR_W-1:0] evt_addr,
    input  logic [7:0]            evt_syn,
    input  logic                  mem_wr_cycle,
    input  logic [CHK_W-1:0]      chk_in,
    output logic [CHK_W-1:0]      chk_out,
    output logic                  nmi_req,
    output logic                  berr_req,
    output logic                  scrub_req
);
    ctl_reg_t              ctl;
    logic                  scrub_off;
    logic                  nmi_en;
    logic                  berr_en;
    logic [1:0]            clr_mask;
    logic                  armed;
    evt_kind_e             kind;
    logic [1:0]            log_flags;
    logic [ADDR_KEEP-1:0]  log_addr;
    logic [SYN_W-1:0]      log_syn;
    cap_reg_t              cap_view;

    ecc_cap_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .ctl       (ctl),
        .scrub_off (scrub_off),
        .nmi_en    (nmi_en),
        .berr_en   (berr_en),
        .clr_mask  (clr_mask)
    );

    ecc_cap_arb u_arb (
        .ce_evt (ce_evt),
        .ue_evt (ue_evt),
        .ecc_on (ctl.ecc_on),
        .armed  (armed),
        .kind   (kind)
    );

    ecc_cap_log #(.ERR_ADDR_W(ERR_ADDR_W)) u_log (
        .clk      (clk),
        .rst      (rst),
        .clr_mask (clr_mask),
        .kind     (kind),
        .evt_addr (evt_addr),
        .evt_syn  (evt_syn),
        .flags    (log_flags),
        .addr_hi  (log_addr),
        .syn_q    (log_syn),
        .armed    (armed)
    );

    ecc_cap_notify u_notify (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .nmi_en    (nmi_en),
        .berr_en   (berr_en),
        .scrub_off (scrub_off),
        .nmi_req   (nmi_req),
        .berr_req  (berr_req),
        .scrub_req (scrub_req)
    );

    ecc_cap_chkmask #(.CHK_W(CHK_W)) u_mask (
        .force_chk    (ctl.force_chk),
        .mem_wr_cycle (mem_wr_cycle),
        .chk_in       (chk_in),
        .chk_out      (chk_out)
    );

    always_comb begin
        cap_view.scrub_off = scrub_off;
        cap_view.addr_hi   = log_addr;
        cap_view.syn       = log_syn;
        cap_view.berr_en   = berr_en;
        cap_view.nmi_en    = nmi_en;
        cap_view.ue        = log_flags[1];
        cap_view.ce        = log_flags[0];
    end

    assign reg_rdata = (reg_sel == SEL_CTL) ? ctl_to_word(ctl) : 32'(cap_view);
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  flags,
    input logic        ecc_on,
    input logic        reg_wr,
    input logic        nmi_req,
    input logic        berr_req,
    input logic        scrub_req,
    input logic [18:0] addr_hi,
    input logic [7:0]  syn_q,
    input logic        force_chk,
    input logic        mem_wr_cycle,
    input logic        chk_any
);
    a_r6_single_flag: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags));

    a_r4_hold_record: assert property (@(posedge clk) disable iff (rst)
        (flags != 2'b00 && !reg_wr) |=> ($stable(flags) && $stable(addr_hi) && $stable(syn_q)));

    a_r8_gated_off: assert property (@(posedge clk) disable iff (rst)
        (!ecc_on && flags == 2'b00) |=> (flags == 2'b00));

    a_r9_nmi_cause: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> flags[0]);

    a_r10_berr_cause: assert property (@(posedge clk) disable iff (rst)
        berr_req |-> flags[1]);

    a_r11_scrub_cause: assert property (@(posedge clk) disable iff (rst)
        scrub_req |-> flags[0]);

    a_r13_forced_zero: assert property (@(posedge clk) disable iff (rst)
        (force_chk && mem_wr_cycle) |-> !chk_any);
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .flags        (log_flags),
    .ecc_on       (ctl.ecc_on),
    .reg_wr       (reg_wr),
    .nmi_req      (nmi_req),
    .berr_req     (berr_req),
    .scrub_req    (scrub_req),
    .addr_hi      (log_addr),
    .syn_q        (log_syn),
    .force_chk    (ctl.force_chk),
    .mem_wr_cycle (mem_wr_cycle),
    .chk_any      (|chk_out)
);

// File: tb/ecc_err_capture_tb.sv
module ecc_err_capture_tb;
    localparam int AW = 33;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          ce_evt = 1'b0;
    logic          ue_evt = 1'b0;
    logic [AW-1:0] evt_addr = '0;
    logic [7:0]    evt_syn = '0;
    logic          mem_wr_cycle = 1'b0;
    logic [CW-1:0] chk_in = '0;
    logic [CW-1:0] chk_out;
    logic          nmi_req, berr_req, scrub_req;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    logic [18:0] last_a = '0;
    logic [7:0]  last_s = '0;

    always #4 clk = ~clk;

    ecc_err_capture #(.ERR_ADDR_W(AW), .CHK_W(CW)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ce_evt(ce_evt),
        .ue_evt(ue_evt), .evt_addr(evt_addr), .evt_syn(evt_syn),
        .mem_wr_cycle(mem_wr_cycle), .chk_in(chk_in), .chk_out(chk_out),
        .nmi_req(nmi_req), .berr_req(berr_req), .scrub_req(scrub_req)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cap_word(input logic s, input logic [18:0] a, input logic [7:0] y,
                                             input logic b, input logic n, input logic u, input logic c);
        return {s, a, y, b, n, u, c};
    endfunction

    // All tasks start and end at a falling edge.
    task automatic wr(input logic sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic evt(input logic c, input logic u, input logic [AW-1:0] a, input logic [7:0] y);
        ce_evt = c; ue_evt = u; evt_addr = a; evt_syn = y;
        @(negedge clk);
        ce_evt = 1'b0; ue_evt = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [AW-1:0] a;
        logic [7:0] y;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(1'b0, r); check("R1 capture reg after reset", r, 0);
        rd(1'b1, r); check("R1 control reg after reset", r, 0);
        check("R1 requests after reset", {nmi_req, berr_req, scrub_req}, 0);
        chk_in = 8'hA5; mem_wr_cycle = 1'b1; #1;
        check("R1 check bits pass", chk_out, 8'hA5);
        mem_wr_cycle = 1'b0;

        // Sweep: event kind x enables x ECC on; covers R2 R3 R6 R8 R9 R10 R11
        for (int k = 0; k < 4; k++) begin
            for (int en = 0; en < 8; en++) begin
                for (int e = 0; e < 2; e++) begin
                    logic ce_x, ue_x, took;
                    logic [2:0] req_x;
                    wr(1'b1, 32'(e));
                    wr(1'b0, cap_word(en[2], '0, '0, en[1], en[0], 1'b1, 1'b1));
                    a = 33'h1_2345_6789 ^ (33'(k * 16 + en * 2 + e) * 33'h0_0101_4321);
                    y = 8'(k * 37 + en * 11 + e * 5 + 3);
                    evt(k[0], k[1], a, y);
                    took = (e == 1) && (k != 0);
                    ue_x = took && k[1];
                    ce_x = took && (k == 1);
                    if (took) begin
                        last_a = a[32:14];
                        last_s = y;
                    end
                    req_x = {ce_x && en[0], ue_x && en[1], ce_x && !en[2]};
                    check("R9 R10 R11 R6 R8 request pulse", {nmi_req, berr_req, scrub_req}, req_x);
                    rd(1'b0, r);
                    check("R2 R3 R6 R8 capture readback", r,
                          cap_word(en[2], last_a, last_s, en[1], en[0], ue_x, ce_x));
                    @(negedge clk);
                    check("R9 R10 R11 pulse ends", {nmi_req, berr_req, scrub_req}, 0);
                end
            end
        end

        // R4: first error holds against a later one
        wr(1'b1, 32'h1);
        wr(1'b0, 32'h0000_000F);
        evt(1'b1, 1'b0, 33'h0_ABCD_4000, 8'h3C);
        evt(1'b0, 1'b1, 33'h1_FFFF_C000, 8'hC3);
        check("R4 no bus error from second event", berr_req, 0);
        evt(1'b1, 1'b0, 33'h0_0000_4000, 8'h11);
        check("R4 no interrupt while held", nmi_req, 0);
        rd(1'b0, r);
        check("R4 record held", r, cap_word(1'b0, 19'h2AF3_5, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b1));

        // R5: write of 0 and clear of the unset flag leave the set flag
        wr(1'b0, 32'h0000_000E);
        rd(1'b0, r); check("R5 clear of other flag ignored", r[1:0], 2'b01);
        wr(1'b0, 32'h0000_000C);
        rd(1'b0, r); check("R5 write zero ignored", r[1:0], 2'b01);
        evt(1'b0, 1'b1, 33'h0_1111_0000, 8'h22);
        rd(1'b0, r); check("R5 not re-armed", r[1:0], 2'b01);
        wr(1'b0, 32'h0000_000D);
        rd(1'b0, r); check("R5 flag cleared", r[1:0], 2'b00);
        evt(1'b0, 1'b1, 33'h0_1111_0000, 8'h22);
        check("R5 R10 re-armed bus error", berr_req, 1);
        rd(1'b0, r); check("R5 re-armed capture", r, cap_word(1'b0, 19'h0444_4, 8'h22, 1'b1, 1'b1, 1'b1, 1'b0));

        // R7: clear and new error in the same cycle
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_000E;
        ce_evt = 1'b1; evt_addr = 33'h1_8000_4000; evt_syn = 8'h5A;
        @(negedge clk);
        reg_wr = 1'b0; ce_evt = 1'b0;
        check("R7 new error wins interrupt", {nmi_req, scrub_req}, 2'b11);
        rd(1'b0, r); check("R7 new error captured", r, cap_word(1'b0, 19'h6000_1, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b1));
        // R7 counterpart: a write clearing nothing does not re-arm
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_000E;
        ue_evt = 1'b1; evt_addr = 33'h0_0000_0000; evt_syn = 8'hFF;
        @(negedge clk);
        reg_wr = 1'b0; ue_evt = 1'b0;
        check("R7 no capture without clear", berr_req, 0);
        rd(1'b0, r); check("R7 old record kept", r[11:0], 12'h5AD);

        // R12: RW bits read back, RO fields ignore writes
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, r); check("R12 capture RW bits", r, cap_word(1'b1, 19'h6000_1, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0));
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, r); check("R12 control RW bits", r, 32'h3);
        evt(1'b1, 1'b0, 33'h0_0000_8000, 8'h01);
        check("R11 scrub suppressed", {nmi_req, scrub_req}, 2'b10);

        // R13: forced check bits
        for (int v = 0; v < 16; v++) begin
            for (int w = 0; w < 2; w++) begin
                chk_in = 8'(v * 17 + 1); mem_wr_cycle = w[0]; #1;
                check("R13 forced check bits", chk_out, w[0] ? 8'h00 : 8'(v * 17 + 1));
            end
        end
        wr(1'b1, 32'h1);
        mem_wr_cycle = 1'b1; chk_in = 8'h96; #1;
        check("R13 force off passes", chk_out, 8'h96);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule